// File: doc/BRIEF.md
# Non-volatile RAM store/recall command detector

This block sits beside the data-space decoder of a non-volatile SRAM. It watches the accesses that hit the RAM select and looks for one exact ordered run of six reads. The first five reads are a fixed prefix. The sixth read picks the command: one tail address asks for a software store, which copies the SRAM into the non-volatile array. A second tail address asks for a recall, which copies the array back into the SRAM. A write, or a read to any address that is not the next one expected, cancels a partly matched run. Cycles with no access leave a partial match unchanged.

The block also turns board power events into requests. A power-fail warning becomes an automatic store and a power-up event becomes an automatic recall. Every request is a single-cycle pulse. After a request the block holds a busy flag for a fixed number of cycles. While the flag is set, RAM accesses and power events are ignored, so the slow transfer can finish undisturbed.

Top module: `nvs_cmd_detect`

## Requirements
- R1: After reset, `store_req`, `recall_req` and `busy` are low.
- R2: With `busy` low, consider the reads 0E38h, 31C7h, 03E0h, 3C1Fh and 303Fh in that order, followed by a read of 0FC0h. A read is `ram_sel`=1 and `rd_en`=1 with `wr_en`=0. After these six reads, `store_req` is high for exactly the one cycle that follows the clock edge that sampled the sixth read.
- R3: The same five-read prefix followed by a read of 0C63h gives the same timing on `recall_req`.
- R4: A write, or a read of any address other than the next expected one, cancels the run. A write is `ram_sel`=1 and `wr_en`=1; it wins over `rd_en`. After the prefix, a sixth read that is neither tail address gives no pulse.
- R5: A cancelling read of 0E38h is taken as the first read of a new run.
- R6: Only `addr[14:0]` is compared, so bit 15 does not matter. Cycles with `ram_sel` low, or with neither strobe set, neither advance nor cancel a run.
- R7: `busy` rises together with each request pulse and stays high for BUSY_CYC cycles (default 8). While it is high, accesses and power events are ignored and produce no pulse. A new run only starts after `busy` falls.
- R8: With `busy` low, a `pwr_fail` cycle gives a `store_req` pulse and a `pwr_up` cycle gives a `recall_req` pulse, each in the following cycle.
- R9: Only one request is issued per cycle. `pwr_fail` wins over `pwr_up`, and `pwr_up` wins over a completed read run. The losing event is dropped. `store_req` and `recall_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_sel | input | 1 | Access targets the non-volatile RAM |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | ADDR_W (16) | Access address |
| pwr_up | input | 1 | Power-up event pulse |
| pwr_fail | input | 1 | Power-down warning pulse |
| store_req | output | 1 | Store request pulse |
| recall_req | output | 1 | Recall request pulse |
| busy | output | 1 | Transfer in progress; RAM accesses are ignored |

## Verification
The assertions assume that every access and power event lasts exactly one clock cycle. They also assume that the power inputs arrive as isolated pulses rather than held levels. The stimulus meets this by driving each strobe for one cycle on the falling edge and returning it to zero before the next access. Command runs are only started once `busy` has been observed low. The one exception is the busy-window case, which sends a deliberately ignored run while the flag is set, in order to show at the pulse outputs that nothing is issued.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  localparam int SEQ_LEN = 6;
  localparam int MATCH_W = 15;
  localparam int STEP_W  = $clog2(SEQ_LEN);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

  localparam logic [MATCH_W-1:0] STORE_TAIL  = 15'h0FC0;
  localparam logic [MATCH_W-1:0] RECALL_TAIL = 15'h0C63;

  typedef enum logic [1:0] {
    REQ_NONE   = 2'd0,
    REQ_STORE  = 2'd1,
    REQ_RECALL = 2'd2
  } req_e;

  // Address expected at a given position of the shared prefix.
  function automatic logic [MATCH_W-1:0] prefix_code(input logic [STEP_W-1:0] idx);
    case (idx)
      3'd0:    prefix_code = 15'h0E38;
      3'd1:    prefix_code = 15'h31C7;
      3'd2:    prefix_code = 15'h03E0;
      3'd3:    prefix_code = 15'h3C1F;
      default: prefix_code = 15'h303F;
    endcase
  endfunction
endpackage

// File: rtl/nvs_rst_sync.sv
module nvs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/nvs_seq_tracker.sv
module nvs_seq_tracker
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              clr,
  output req_e              hit
);
  logic [STEP_W-1:0]  step_q, step_d;
  logic [MATCH_W-1:0] key;
  logic               is_rd;
  logic               step_en;

  assign key     = acc_addr[MATCH_W-1:0];
  assign is_rd   = acc_en && !acc_wr;
  assign step_en = acc_en || clr;

  // Completion decode: independent of clr to keep the go path acyclic.
  always_comb begin
    hit = REQ_NONE;
    if (is_rd && step_q == LAST_STEP) begin
      if (key == STORE_TAIL)       hit = REQ_STORE;
      else if (key == RECALL_TAIL) hit = REQ_RECALL;
    end
  end

  always_comb begin
    step_d = step_q;
    if (clr) begin
      step_d = '0;
    end else if (acc_en) begin
      if (hit != REQ_NONE)
        step_d = '0;
      else if (is_rd && step_q != LAST_STEP && key == prefix_code(step_q))
        step_d = step_q + 1'b1;
      else if (is_rd && key == prefix_code('0))
        step_d = STEP_W'(1);
      else
        step_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_d;
  end
endmodule

// File: rtl/nvs_req_arb.sv
module nvs_req_arb
  import nvs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail,
  input  logic pwr_up,
  input  req_e seq_hit,
  input  logic busy,
  output logic go,
  output logic store_q,
  output logic recall_q
);
  logic go_store, go_recall;

  always_comb begin
    go_store  = 1'b0;
    go_recall = 1'b0;
    if (!busy) begin
      if (pwr_fail)                    go_store  = 1'b1;
      else if (pwr_up)                 go_recall = 1'b1;
      else if (seq_hit == REQ_STORE)   go_store  = 1'b1;
      else if (seq_hit == REQ_RECALL)  go_recall = 1'b1;
    end
  end

  assign go = go_store || go_recall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q  <= 1'b0;
      recall_q <= 1'b0;
    end else begin
      store_q  <= go_store;
      recall_q <= go_recall;
    end
  end
endmodule

// File: rtl/nvs_busy_timer.sv
module nvs_busy_timer #(
  parameter int BUSY_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = CNT_W'(BUSY_CYC);
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/nvs_cmd_detect.sv
module nvs_cmd_detect
  import nvs_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BUSY_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pwr_up,
  input  logic              pwr_fail,
  output logic              store_req,
  output logic              recall_req,
  output logic              busy
);
  logic rst_n_int;
  logic acc_en;
  logic go;
  req_e seq_hit;

  nvs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign acc_en = ram_sel && (rd_en || wr_en) && !busy;

  nvs_seq_tracker #(.ADDR_W(ADDR_W)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .acc_en   (acc_en),
    .acc_wr   (wr_en),
    .acc_addr (addr),
    .clr      (go),
    .hit      (seq_hit)
  );

  nvs_req_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .pwr_fail (pwr_fail),
    .pwr_up   (pwr_up),
    .seq_hit  (seq_hit),
    .busy     (busy),
    .go       (go),
    .store_q  (store_req),
    .recall_q (recall_req)
  );

  nvs_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk   (clk),
    .rst_n (rst_n_int),
    .load  (go),
    .busy  (busy)
  );
endmodule

// File: rtl/nvs_cmd_detect_chk.sv
module nvs_cmd_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic ram_sel,
  input logic wr_en,
  input logic pwr_up,
  input logic pwr_fail,
  input logic store_req,
  input logic recall_req,
  input logic busy
);
  // R9
  excl_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req));

  // R9
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);

  // R9
  recall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> !recall_req);

  // R7
  busy_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |-> busy);

  // R7
  req_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |-> !$past(busy));

  // R8
  pwr_fail_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_fail && !busy) |=> store_req);

  // R4
  wr_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_sel && wr_en && !pwr_fail && !pwr_up) |=> !(store_req || recall_req));
endmodule

bind nvs_cmd_detect nvs_cmd_detect_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ram_sel    (ram_sel),
  .wr_en      (wr_en),
  .pwr_up     (pwr_up),
  .pwr_fail   (pwr_fail),
  .store_req  (store_req),
  .recall_req (recall_req),
  .busy       (busy)
);

// File: tb/nvs_cmd_detect_tb.sv
module nvs_cmd_detect_tb_top;
  localparam int BUSY_CYC = 8;
  localparam int K_STORE  = 1;
  localparam int K_RECALL = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ram_sel, rd_en, wr_en, pwr_up, pwr_fail;
  logic [15:0] addr;
  logic        store_req, recall_req, busy;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  int    exp_kind[$];
  int    exp_cyc[$];
  string exp_tag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvs_cmd_detect #(.ADDR_W(16), .BUSY_CYC(BUSY_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ram_sel(ram_sel), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .pwr_up(pwr_up), .pwr_fail(pwr_fail),
    .store_req(store_req), .recall_req(recall_req), .busy(busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Scoreboard push: pulse expected after the coming edge.
  task automatic expect_req(input int kind, input string tag);
    exp_kind.push_back(kind);
    exp_cyc.push_back(cyc + 1);
    exp_tag.push_back(tag);
  endtask

  // Monitor: pops an expectation for every pulse observed.
  always @(negedge clk) begin
    if (rst_n && (store_req || recall_req)) begin
      int kind;
      kind = (store_req ? K_STORE : 0) + (recall_req ? K_RECALL : 0);
      if (exp_kind.size() == 0) begin
        check("unexpected pulse R4", kind, 0);
      end else begin
        int    ek, ec;
        string et;
        ek = exp_kind.pop_front();
        ec = exp_cyc.pop_front();
        et = exp_tag.pop_front();
        check({et, " kind"}, kind, ek);
        check({et, " cycle"}, cyc, ec);
      end
    end
  end

  task automatic acc(input logic s, input logic r, input logic w, input logic [15:0] a);
    ram_sel = s; rd_en = r; wr_en = w; addr = a;
    @(negedge clk);
    ram_sel = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    acc(1'b1, 1'b1, 1'b0, a);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prefix(input logic [15:0] hi);
    rd(16'h0E38 | hi); rd(16'h31C7 | hi); rd(16'h03E0 | hi);
    rd(16'h3C1F | hi); rd(16'h303F | hi);
  endtask

  task automatic settle();
    idle(BUSY_CYC + 3);
  endtask

  initial begin
    rst_n = 1'b0; ram_sel = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    addr = '0; pwr_up = 1'b0; pwr_fail = 1'b0;
    idle(3);
    // R1: reset state
    check("R1 store_req", int'(store_req), 0);
    check("R1 recall_req", int'(recall_req), 0);
    check("R1 busy", int'(busy), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    check("R1 busy after release", int'(busy), 0);

    // R2: store run, then busy window R7
    prefix(16'h0000);
    expect_req(K_STORE, "R2 store");
    rd(16'h0FC0);
    check("R7 busy with pulse", int'(busy), 1);
    idle(BUSY_CYC - 1);
    check("R7 busy last cycle", int'(busy), 1);
    idle(1);
    check("R7 busy released", int'(busy), 0);
    settle();

    // R3: recall run with idle gaps (R6)
    rd(16'h0E38); idle(2); rd(16'h31C7); rd(16'h03E0); idle(1);
    rd(16'h3C1F); rd(16'h303F);
    expect_req(K_RECALL, "R3 recall");
    rd(16'h0C63);
    settle();

    // R4: write in the middle cancels
    rd(16'h0E38); rd(16'h31C7); rd(16'h03E0);
    acc(1'b1, 1'b0, 1'b1, 16'h3C1F);
    rd(16'h3C1F); rd(16'h303F); rd(16'h0FC0);
    settle();

    // R4: wrong sixth read gives nothing, then run restarts cleanly
    prefix(16'h0000); rd(16'h0FC1);
    rd(16'h0C63);
    settle();

    // R5: cancelling 0E38 starts a new run
    rd(16'h0E38); rd(16'h31C7); rd(16'h0E38);
    rd(16'h31C7); rd(16'h03E0); rd(16'h3C1F); rd(16'h303F);
    expect_req(K_STORE, "R5 restart store");
    rd(16'h0FC0);
    settle();

    // R6: bit 15 ignored, deselected access ignored
    rd(16'h8E38); rd(16'hB1C7); rd(16'h83E0);
    acc(1'b0, 1'b1, 1'b0, 16'h1234);
    acc(1'b0, 1'b0, 1'b1, 16'h1234);
    rd(16'hBC1F); rd(16'hB03F);
    expect_req(K_RECALL, "R6 masked recall");
    rd(16'h8C63);
    settle();

    // R7: run sent while busy is ignored
    prefix(16'h0000);
    expect_req(K_STORE, "R7 first store");
    rd(16'h0FC0);
    prefix(16'h0000); rd(16'h0C63);
    pwr_up = 1'b1; @(negedge clk); pwr_up = 1'b0;
    settle();
    check("R7 idle after window", int'(busy), 0);
    prefix(16'h0000);
    expect_req(K_RECALL, "R7 recall after window");
    rd(16'h0C63);
    settle();

    // R8: power events
    expect_req(K_STORE, "R8 pwr_fail store");
    pwr_fail = 1'b1; @(negedge clk); pwr_fail = 1'b0;
    settle();
    expect_req(K_RECALL, "R8 pwr_up recall");
    pwr_up = 1'b1; @(negedge clk); pwr_up = 1'b0;
    settle();

    // R9: priorities
    expect_req(K_STORE, "R9 fail over up");
    pwr_fail = 1'b1; pwr_up = 1'b1; @(negedge clk);
    pwr_fail = 1'b0; pwr_up = 1'b0;
    settle();
    prefix(16'h0000);
    expect_req(K_RECALL, "R9 up over run");
    pwr_up = 1'b1; rd(16'h0FC0); pwr_up = 1'b0;
    settle();

    check("R2 all expected pulses seen", exp_kind.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule